// File: doc/BRIEF.md
# UART with FIFOs and flow control

This block is a full-duplex asynchronous serial transceiver. A host pushes characters into a 16-entry transmit queue and pops received characters from a 16-entry receive queue. A built-in divider sets the line rate. The character format is chosen by a few configuration inputs: 7 or 8 data bits, 1 or 2 stop bits, and even, odd or no parity. Both queue fill levels are visible at all times, and a set of level-style interrupt requests reports the conditions that need the host's attention.

The receiver samples the line sixteen times per bit. It rejects short low glitches on the line and checks every frame for parity errors, framing errors, overrun and a line break. Once any error flag is up, it stops storing characters until the host clears the flags. A saturating counter keeps the number of errored frames. A timeout flag tells the host that characters are waiting in the receive queue while the line has gone quiet. Two active-low modem lines give hardware flow control. The transmitter will not start a character while the far end holds its clear-to-send line high. The receiver raises its own request-to-send line as its queue nears full.

Top module: `uart_fc`

## Requirements
- R1: The transmit line idles high. Each character is sent as a low start bit, then the data bits LSB first (8 when `cfg_len8`=1, else the low 7 bits), then an optional parity bit, then one stop bit (two when `cfg_stop2`=1), all high. Each bit lasts 16 x `cfg_div` clock cycles.
- R2: `cfg_par` encodes the parity as follows: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 means none. Even parity makes the total count of ones in data plus parity even. Odd parity makes it odd.
- R3: While `cts_n` is high, no new character starts and the transmit queue keeps its contents. A character already in progress completes.
- R4: The receiver checks the start bit at its midpoint. A low pulse on `rxd` shorter than half a bit receives nothing and sets no flag.
- R5: A received frame with no error is appended to the receive queue. `rx_level` counts the stored characters, `rd_data` shows the oldest one (right-aligned, bit 7 zero in 7-bit mode), and `rd_en` removes it.
- R6: A parity mismatch sets `err_parity`. A low first stop bit sets `err_frame`, unless the frame is a break. The frame is discarded in both cases.
- R7: A break is a frame whose data bits, parity bit (if enabled) and stop bit are all low. It sets `brk_det` and `irq_brk`, stores nothing, leaves `err_parity` and `err_frame` unchanged, and makes the receiver wait for `rxd` to return high.
- R8: While any of `err_parity`, `err_frame`, `err_overrun` or `brk_det` is set, received frames are discarded. A one-cycle `err_clr` pulse clears all four flags.
- R9: A good frame that arrives while the receive queue holds 16 characters sets `err_overrun` and is dropped.
- R10: `err_count` rises by one for each parity, framing or overrun event, saturates at all ones, and is not cleared by `err_clr`.
- R11: `rx_timeout` is set when the receive queue is non-empty and four character times (64 x frame bits x `cfg_div` cycles) have passed since the last frame end or the last read, whichever came later. A read or a new frame clears it.
- R12: `rts_n` is high while `rx_level` is at least 14 and low otherwise.
- R13: `tx_level` counts the queued transmit characters. A write to a full transmit queue is dropped. `irq_tx_empty` is high when the transmit queue is empty, `irq_rx_full` when `rx_level` is at least 8, and `irq_rx_err` when any of `err_parity`, `err_frame` or `err_overrun` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 12 | Clocks per oversample tick (0 acts as 1) |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits on transmit |
| cfg_par | input | 2 | Parity select |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Character to send |
| rd_en | input | 1 | Pop the oldest received character |
| rd_data | output | 8 | Oldest received character |
| err_clr | input | 1 | Clear the error and break flags |
| tx_level | output | 5 | Transmit queue fill level |
| rx_level | output | 5 | Receive queue fill level |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| brk_det | output | 1 | Sticky break detected |
| err_count | output | 8 | Saturating receive error count |
| rx_timeout | output | 1 | Idle data waiting in receive queue |
| irq_tx_empty | output | 1 | Transmit queue empty request |
| irq_rx_full | output | 1 | Receive queue level request |
| irq_rx_err | output | 1 | Receive error request |
| irq_brk | output | 1 | Break request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench uses the default parameters: 16-entry queues, a request-to-send threshold of 14 and a receive interrupt level of 8. It drives `cfg_div` = 1, so one bit lasts 16 clocks. At that rate, filling the receive queue, crossing the 13/14 flow-control boundary, overrunning on the seventeenth character and waiting out the four-character timeout all fit in a few thousand cycles. Serial frames are built and decoded bit by bit in the bench from the stated formats, with 8N1, 7E2, 7O1 and 8E1 among them.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE3 = 2'b11
  } par_e;

  function automatic logic par_on(input logic [1:0] pm);
    return (pm == PAR_EVEN) || (pm == PAR_ODD);
  endfunction

  // parity bit value that completes the requested sense
  function automatic logic par_calc(input logic [7:0] d, input logic len8, input logic [1:0] pm);
    logic x;
    x = len8 ? ^d : ^d[6:0];
    return x ^ (pm == PAR_ODD);
  endfunction

  // total bits on the wire, start bit included
  function automatic logic [3:0] frame_len(input logic len8, input logic pon, input logic stop2);
    return 4'd9 + {3'b0, len8} + {3'b0, pon} + {3'b0, stop2};
  endfunction

  // LSB-first wire image, bit 0 = start, unused upper bits stay high (stop)
  function automatic logic [11:0] build_frame(input logic [7:0] d, input logic len8, input logic [1:0] pm);
    logic [11:0] f;
    f = len8 ? {3'b111, d, 1'b0} : {4'b1111, d[6:0], 1'b0};
    if (par_on(pm)) begin
      if (len8) f[9] = par_calc(d, len8, pm);
      else      f[8] = par_calc(d, len8, pm);
    end
    return f;
  endfunction

endpackage

// File: rtl/uart_fc_baud.sv
module uart_fc_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last  = (div == '0) ? '0 : div - 1'b1;
    tick  = (cnt_q >= last);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: with a divisor above one, ticks never come back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1 && $stable(div)) |=> !tick);

endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  // DEPTH is expected to be a power of two so the pointers wrap naturally
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign dout  = mem[rp_q];

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = wp_q + AW'(do_push);
    rp_d    = rp_q + AW'(do_pop);
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  // R13: a push into a full queue with no pop leaves the level alone
  p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       len8,
  input  logic       stop2,
  input  logic [1:0] par_mode,
  input  logic       cts_hold,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       q_pop,
  output logic       txd
);
  logic        busy_q, busy_d;
  logic [11:0] sh_q, sh_d;
  logic [3:0]  nb_q, nb_d;
  logic [3:0]  tc_q, tc_d;
  logic        txd_q, txd_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    nb_d   = nb_q;
    tc_d   = tc_q;
    q_pop  = 1'b0;
    if (!busy_q) begin
      if (!q_empty && !cts_hold) begin
        q_pop  = 1'b1;
        busy_d = 1'b1;
        sh_d   = build_frame(q_data, len8, par_mode);
        nb_d   = frame_len(len8, par_on(par_mode), stop2);
        tc_d   = '0;
      end
    end else if (tick) begin
      if (tc_q == 4'd15) begin
        tc_d = '0;
        sh_d = {1'b1, sh_q[11:1]};
        nb_d = nb_q - 4'd1;
        if (nb_q == 4'd1) busy_d = 1'b0;
      end else begin
        tc_d = tc_q + 4'd1;
      end
    end
    txd_d = busy_d ? sh_d[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      nb_q   <= '0;
      tc_q   <= '0;
      txd_q  <= 1'b1;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      nb_q   <= nb_d;
      tc_q   <= tc_d;
      txd_q  <= txd_d;
    end
  end

  assign txd = txd_q;

  // R3: an idle transmitter stays idle while the far end holds off
  p_cts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cts_hold) |=> !busy_q);

  // R1: every character begins with a low start bit on the line
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_q);

endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       len8,
  input  logic [1:0] par_mode,
  input  logic       rxd,
  input  logic       err_clr,
  input  logic       q_full,
  output logic       push,
  output logic [7:0] push_data,
  output logic       frame_done,
  output logic       err_inc,
  output logic       pe_flag,
  output logic       fe_flag,
  output logic       oe_flag,
  output logic       brk_flag
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rx_st_e;

  rx_st_e     st_q, st_d;
  logic [3:0] tc_q, tc_d;
  logic [2:0] bc_q, bc_d;
  logic [7:0] sh_q, sh_d;
  logic       pb_q, pb_d;
  logic       pe_q, fe_q, oe_q, bk_q;
  logic       pe_d, fe_d, oe_d, bk_d;
  logic       pe_e, fe_e, oe_e, bk_e;
  logic       pon, blocked;
  logic [7:0] data;

  always_comb begin
    st_d = st_q; tc_d = tc_q; bc_d = bc_q; sh_d = sh_q; pb_d = pb_q;
    push = 1'b0; frame_done = 1'b0;
    pe_e = 1'b0; fe_e = 1'b0; oe_e = 1'b0; bk_e = 1'b0;
    pon     = par_on(par_mode);
    blocked = pe_q | fe_q | oe_q | bk_q;
    data    = len8 ? sh_q : {1'b0, sh_q[7:1]};
    case (st_q)
      RX_IDLE: if (tick && !rxd) begin
        st_d = RX_START;
        tc_d = '0;
      end
      RX_START: if (tick) begin
        if (tc_q == 4'd7) begin
          tc_d = '0; bc_d = '0; sh_d = '0; pb_d = 1'b0;
          st_d = rxd ? RX_IDLE : RX_DATA;
        end else tc_d = tc_q + 4'd1;
      end
      RX_DATA: if (tick) begin
        if (tc_q == 4'd15) begin
          tc_d = '0;
          sh_d = {rxd, sh_q[7:1]};
          bc_d = bc_q + 3'd1;
          if (bc_q == (len8 ? 3'd7 : 3'd6)) st_d = pon ? RX_PAR : RX_STOP;
        end else tc_d = tc_q + 4'd1;
      end
      RX_PAR: if (tick) begin
        if (tc_q == 4'd15) begin
          tc_d = '0;
          pb_d = rxd;
          st_d = RX_STOP;
        end else tc_d = tc_q + 4'd1;
      end
      RX_STOP: if (tick) begin
        if (tc_q == 4'd15) begin
          tc_d       = '0;
          frame_done = 1'b1;
          if (!rxd && data == '0 && !(pon && pb_q)) begin
            bk_e = 1'b1;
            st_d = RX_WAIT;
          end else begin
            st_d = RX_IDLE;
            fe_e = !rxd;
            pe_e = pon && (pb_q != par_calc(data, len8, par_mode));
            if (!fe_e && !pe_e && !blocked) begin
              if (q_full) oe_e = 1'b1;
              else        push = 1'b1;
            end
          end
        end else tc_d = tc_q + 4'd1;
      end
      RX_WAIT: if (rxd) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
    pe_d = (pe_q & !err_clr) | pe_e;
    fe_d = (fe_q & !err_clr) | fe_e;
    oe_d = (oe_q & !err_clr) | oe_e;
    bk_d = (bk_q & !err_clr) | bk_e;
    err_inc   = pe_e | fe_e | oe_e;
    push_data = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; tc_q <= '0; bc_q <= '0; sh_q <= '0; pb_q <= 1'b0;
      pe_q <= 1'b0; fe_q <= 1'b0; oe_q <= 1'b0; bk_q <= 1'b0;
    end else begin
      st_q <= st_d; tc_q <= tc_d; bc_q <= bc_d; sh_q <= sh_d; pb_q <= pb_d;
      pe_q <= pe_d; fe_q <= fe_d; oe_q <= oe_d; bk_q <= bk_d;
    end
  end

  assign pe_flag  = pe_q;
  assign fe_flag  = fe_q;
  assign oe_flag  = oe_q;
  assign brk_flag = bk_q;

  // R8: nothing reaches the queue while a flag is pending
  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_q || fe_q || oe_q || bk_q) |-> !push);

  // R7: a break never raises a parity or framing flag by itself
  p_brk_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_e && !fe_q && !pe_q) |=> (!fe_q && !pe_q));

endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int DIV_W  = 12,
  parameter  int CNT_W  = 8,
  parameter  int RTS_TH = 14,
  parameter  int RX_TRIG = 8,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_len8,
  input  logic             cfg_stop2,
  input  logic [1:0]       cfg_par,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             err_clr,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun,
  output logic             brk_det,
  output logic [CNT_W-1:0] err_count,
  output logic             rx_timeout,
  output logic             irq_tx_empty,
  output logic             irq_rx_full,
  output logic             irq_rx_err,
  output logic             irq_brk,
  output logic             txd,
  input  logic             rxd,
  input  logic             cts_n,
  output logic             rts_n
);
  localparam int TW = 10;  // holds 64 x 12 bits

  logic             tick;
  logic [1:0]       rxd_sy, cts_sy;
  logic             tx_pop, tx_empty, tx_full, tx_pop_unused;
  logic [7:0]       tx_head;
  logic             rx_push, rx_full, rx_empty, rx_done, rx_inc;
  logic [7:0]       rx_din;
  logic [CNT_W-1:0] ecnt_q, ecnt_d;
  logic [TW-1:0]    to_q, to_d, to_lim;
  logic             rts_q, rts_d;

  uart_fc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick));

  uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(tx_pop),
    .dout(tx_head), .count(tx_level), .full(tx_full), .empty(tx_empty));

  uart_fc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len8(cfg_len8), .stop2(cfg_stop2),
    .par_mode(cfg_par), .cts_hold(cts_sy[1]), .q_empty(tx_empty),
    .q_data(tx_head), .q_pop(tx_pop), .txd(txd));

  uart_fc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len8(cfg_len8), .par_mode(cfg_par),
    .rxd(rxd_sy[1]), .err_clr(err_clr), .q_full(rx_full), .push(rx_push),
    .push_data(rx_din), .frame_done(rx_done), .err_inc(rx_inc),
    .pe_flag(err_parity), .fe_flag(err_frame), .oe_flag(err_overrun),
    .brk_flag(brk_det));

  uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rd_en),
    .dout(rd_data), .count(rx_level), .full(rx_full), .empty(rx_empty));

  assign tx_pop_unused = tx_full;

  always_comb begin
    ecnt_d = ecnt_q;
    if (rx_inc && ecnt_q != '1) ecnt_d = ecnt_q + 1'b1;
    to_lim = {frame_len(cfg_len8, par_on(cfg_par), cfg_stop2), 6'b0};
    if (rx_done || rd_en || rx_empty) to_d = '0;
    else if (tick && to_q < to_lim)   to_d = to_q + 1'b1;
    else                              to_d = to_q;
    rts_d = (rx_level >= LVL_W'(RTS_TH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_sy <= 2'b11;
      cts_sy <= 2'b11;
      ecnt_q <= '0;
      to_q   <= '0;
      rts_q  <= 1'b0;
    end else begin
      rxd_sy <= {rxd_sy[0], rxd};
      cts_sy <= {cts_sy[0], cts_n};
      ecnt_q <= ecnt_d;
      to_q   <= to_d;
      rts_q  <= rts_d;
    end
  end

  assign err_count    = ecnt_q;
  assign rx_timeout   = !rx_empty && (to_q >= to_lim);
  assign rts_n        = rts_q;
  assign irq_tx_empty = tx_empty;
  assign irq_rx_full  = (rx_level >= LVL_W'(RX_TRIG));
  assign irq_rx_err   = err_parity | err_frame | err_overrun;
  assign irq_brk      = brk_det;

  // R12: a queue at or above threshold throttles the far end next cycle
  p_rts_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= LVL_W'(RTS_TH)) |=> rts_n);

  // R11: a read drops the timeout flag
  p_tout_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_timeout) |=> !rx_timeout);

  // R10: the error count moves by at most one per cycle and never falls
  p_errcnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

endmodule

// File: tb/sim_uart_fc.sv
module sim_uart_fc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] cfg_div;
  logic        cfg_len8, cfg_stop2;
  logic [1:0]  cfg_par;
  logic        wr_en, rd_en, err_clr;
  logic [7:0]  wr_data, rd_data;
  logic [4:0]  tx_level, rx_level;
  logic        err_parity, err_frame, err_overrun, brk_det;
  logic [7:0]  err_count;
  logic        rx_timeout, irq_tx_empty, irq_rx_full, irq_rx_err, irq_brk;
  logic        txd, rxd, cts_n, rts_n;

  int errors = 0;
  int checks = 0;
  int ecnt   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  uart_fc u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len8(cfg_len8),
    .cfg_stop2(cfg_stop2), .cfg_par(cfg_par), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .err_clr(err_clr), .tx_level(tx_level),
    .rx_level(rx_level), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .brk_det(brk_det), .err_count(err_count),
    .rx_timeout(rx_timeout), .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
    .irq_rx_err(irq_rx_err), .irq_brk(irq_brk), .txd(txd), .rxd(rxd),
    .cts_n(cts_n), .rts_n(rts_n));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic ref_par(input logic [7:0] d, input logic l8, input logic odd);
    logic p = odd;
    for (int i = 0; i < 8; i++) if (i < 7 || l8) p ^= d[i];
    return p;
  endfunction

  function automatic logic [11:0] ref_frame(input logic [7:0] d, input logic l8, input logic [1:0] pm);
    logic [11:0] f = '1;
    int k = 1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < 7 || l8) begin f[k] = d[i]; k++; end
    if (pm == 2'b01 || pm == 2'b10) f[k] = ref_par(d, l8, pm == 2'b10);
    return f;
  endfunction

  task automatic rx_send(input logic [7:0] d, input logic l8, input logic [1:0] pm, input logic flip, input logic stopv);
    rxd = 1'b0; clks(16);
    for (int i = 0; i < 8; i++) if (i < 7 || l8) begin rxd = d[i]; clks(16); end
    if (pm == 2'b01 || pm == 2'b10) begin rxd = ref_par(d, l8, pm == 2'b10) ^ flip; clks(16); end
    rxd = stopv; clks(16);
    if (!stopv) begin rxd = 1'b1; clks(16); end
  endtask

  task automatic tx_capture(input int n, output logic [11:0] got);
    int w = 0;
    got = '1;
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    clks(8);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) clks(16);
    end
  endtask

  task automatic drain();
    while (rx_level != 0) begin rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; end
  endtask

  task automatic clear_flags();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  task automatic set_cfg(input logic l8, input logic s2, input logic [1:0] pm);
    cfg_len8 = l8; cfg_stop2 = s2; cfg_par = pm; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "txd idle", txd, 1'b1);
    chk("R12", "rts_n at reset", rts_n, 1'b0);
    chk("R13", "levels at reset", {tx_level, rx_level}, 10'd0);
    chk("R13", "tx empty irq", irq_tx_empty, 1'b1);
    chk("R8", "flags at reset", {err_parity, err_frame, err_overrun, brk_det, rx_timeout}, 5'd0);
  endtask

  task automatic t_tx_8n1();
    logic [11:0] got;
    set_cfg(1, 0, 2'b00);
    wr_data = 8'hA5; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    tx_capture(10, got);
    chk("R1", "8N1 frame A5", got, ref_frame(8'hA5, 1, 2'b00));
    clks(40);
    chk("R13", "tx empty after send", irq_tx_empty, 1'b1);
  endtask

  task automatic t_tx_7e2();
    logic [11:0] got;
    set_cfg(0, 1, 2'b01);
    wr_data = 8'h35; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    tx_capture(11, got);
    chk("R2", "7E2 frame 35 even parity", got, ref_frame(8'h35, 0, 2'b01));
    clks(40);
  endtask

  task automatic t_cts();
    logic [11:0] got;
    logic seen_low = 1'b0;
    set_cfg(1, 0, 2'b10);
    cts_n = 1'b1; clks(4);
    for (int i = 0; i < 3; i++) begin
      wr_data = 8'h3C + 8'(i); wr_en = 1'b1; @(negedge clk);
    end
    wr_en = 1'b0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (!txd) seen_low = 1'b1; end
    chk("R3", "no start while cts_n high", seen_low, 1'b0);
    chk("R13", "tx level while held", tx_level, 5'd3);
    cts_n = 1'b0;
    tx_capture(11, got);
    chk("R2", "8O1 frame 3C after release", got, ref_frame(8'h3C, 1, 2'b10));
    tx_capture(11, got);
    tx_capture(11, got);
    chk("R1", "third queued frame 3E", got, ref_frame(8'h3E, 1, 2'b10));
    clks(20);
    chk("R13", "queue drained", irq_tx_empty, 1'b1);
  endtask

  task automatic t_rx_good();
    set_cfg(1, 0, 2'b00);
    rx_send(8'hC3, 1, 2'b00, 0, 1); clks(4);
    chk("R5", "8N1 stored level", rx_level, 5'd1);
    chk("R5", "8N1 head data", rd_data, 8'hC3);
    drain();
    set_cfg(0, 0, 2'b10);
    rx_send(8'h4B, 0, 2'b10, 0, 1); clks(4);
    chk("R5", "7O1 stored data", rd_data, 8'h4B);
    chk("R2", "7O1 no parity error", err_parity, 1'b0);
    drain();
    chk("R5", "level after read", rx_level, 5'd0);
  endtask

  task automatic t_glitch();
    set_cfg(1, 0, 2'b00);
    rxd = 1'b0; clks(4); rxd = 1'b1; clks(60);
    chk("R4", "glitch stores nothing", rx_level, 5'd0);
    chk("R4", "glitch sets no flag", {err_frame, brk_det}, 2'b00);
  endtask

  task automatic t_parity_block();
    set_cfg(1, 0, 2'b01);
    rx_send(8'h0F, 1, 2'b01, 1, 1); clks(4);
    ecnt++;
    chk("R6", "parity error flag", err_parity, 1'b1);
    chk("R13", "irq_rx_err", irq_rx_err, 1'b1);
    chk("R6", "errored frame discarded", rx_level, 5'd0);
    chk("R10", "count after parity", err_count, 8'(ecnt));
    rx_send(8'h11, 1, 2'b01, 0, 1); clks(4);
    chk("R8", "good frame blocked", rx_level, 5'd0);
    clear_flags();
    chk("R8", "flags cleared", {err_parity, err_frame, err_overrun, brk_det}, 4'd0);
    chk("R10", "count kept after clear", err_count, 8'(ecnt));
    rx_send(8'h22, 1, 2'b01, 0, 1); clks(4);
    chk("R8", "accepted after clear", rd_data, 8'h22);
    drain();
  endtask

  task automatic t_frame();
    set_cfg(1, 0, 2'b00);
    rx_send(8'h5A, 1, 2'b00, 0, 0); clks(4);
    ecnt++;
    chk("R6", "framing flag", err_frame, 1'b1);
    chk("R6", "frame discarded", rx_level, 5'd0);
    chk("R10", "count after framing", err_count, 8'(ecnt));
    clear_flags();
  endtask

  task automatic t_break();
    set_cfg(1, 0, 2'b00);
    rxd = 1'b0; clks(16 * 14); rxd = 1'b1; clks(40);
    chk("R7", "break flag and irq", {brk_det, irq_brk}, 2'b11);
    chk("R7", "no framing on break", {err_frame, err_parity}, 2'b00);
    chk("R7", "break stores nothing", rx_level, 5'd0);
    chk("R10", "break not counted", err_count, 8'(ecnt));
    clear_flags();
    rx_send(8'h77, 1, 2'b00, 0, 1); clks(4);
    chk("R7", "receiver recovers after break", rd_data, 8'h77);
    drain();
  endtask

  task automatic t_timeout();
    set_cfg(1, 0, 2'b00);
    rx_send(8'h99, 1, 2'b00, 0, 1);
    clks(560);
    chk("R11", "no timeout before 4 chars", rx_timeout, 1'b0);
    clks(140);
    chk("R11", "timeout after 4 chars", rx_timeout, 1'b1);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; clks(2);
    chk("R11", "timeout cleared by read", rx_timeout, 1'b0);
  endtask

  task automatic t_fill();
    set_cfg(1, 0, 2'b00);
    for (int i = 0; i < 16; i++) begin
      rx_send(8'h40 + 8'(i), 1, 2'b00, 0, 1); clks(3);
      if (i == 7)  chk("R13", "irq_rx_full at 8", irq_rx_full, 1'b1);
      if (i == 12) chk("R12", "rts_n low at 13", rts_n, 1'b0);
      if (i == 13) chk("R12", "rts_n high at 14", rts_n, 1'b1);
    end
    chk("R5", "level 16", rx_level, 5'd16);
    rx_send(8'hEE, 1, 2'b00, 0, 1); clks(4);
    ecnt++;
    chk("R9", "overrun flag", err_overrun, 1'b1);
    chk("R9", "level stays 16", rx_level, 5'd16);
    chk("R10", "count after overrun", err_count, 8'(ecnt));
    chk("R9", "head keeps first char", rd_data, 8'h40);
    drain();
    clks(2);
    chk("R12", "rts_n low after drain", rts_n, 1'b0);
    clear_flags();
  endtask

  initial begin
    rst_n = 1'b0; cfg_div = 12'd1; cfg_len8 = 1'b1; cfg_stop2 = 1'b0; cfg_par = 2'b00;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; err_clr = 1'b0; rxd = 1'b1; cts_n = 1'b0;
    clks(5); rst_n = 1'b1; clks(4);
    t_reset();
    t_tx_8n1();
    t_tx_7e2();
    t_cts();
    t_rx_good();
    t_glitch();
    t_parity_block();
    t_frame();
    t_break();
    t_timeout();
    t_fill();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule